// File: doc/BRIEF.md
# Calibrated Temperature Converter with Bank Maximum

This block turns raw 12-bit thermal sensor codes into signed temperatures in millidegrees Celsius and reports the hottest reading of a bank. Up to four codes arrive together. Each code carries the index of the physical sensor it came from, so that the matching per-sensor offset is applied. An enable mask says which lanes belong to the bank. The conversion is a single registered stage. The bank maximum is produced in the same cycle as the per-lane results.

The calibration set is gain error, one offset per sensor, reference temperature, and a slope trim with its sign qualifiers. It is captured on a load pulse. Each load starts an iterative two-step division that derives a scale factor. New conversions are accepted only once that scale is valid. After reset the block loads the uncalibrated defaults and computes their scale without being asked.

All arithmetic is 32-bit two's complement. Every right shift is arithmetic. Readings that come out implausibly hot, as a sensor's first sample often does, are forced to zero before the maximum is taken.

Top module: `thermo_cal_max`

## Requirements
- R1: While reset is held and directly after it, `busy` is 1 and `in_ready` and `out_valid` are 0. Reset loads gain error 512, offset 260 for every sensor, reference 40 and slope trim 0, then computes their scale without a load pulse.
- R2: A `cal_load` pulse captures all calibration inputs and raises `busy`. Exactly 64 clock edges after the capturing edge, `done` pulses for one cycle and `busy` falls. `busy` and `in_ready` are never 1 together.
- R3: The effective slope trim is minus `cal_slope` only when `cal_slope_neg` and `cal_slope_id` are both 1. In every other case it is plus `cal_slope`.
- R4: Only bits [11:0] of each 16-bit lane of `in_code` are used. Bits [15:12] have no effect on any result.
- R5: scale = 1627604160 / (165 + slope) / (10000 + gain error), each division truncating. Each lane then gives ref×500 − ((scale × (code − offset[sel] − 3350)) >>> 3), computed in 32-bit signed arithmetic.
- R6: A lane value above 200000 is output as 0 and is used as 0 for the maximum.
- R7: `out_max` is the largest lane value among the lanes whose `in_en` bit was set. When no lane is enabled it is −2147483648 (32'h80000000).
- R8: A conversion is accepted on an edge where `in_valid` and `in_ready` are both 1. Its results appear with `out_valid` = 1 for exactly the following cycle. `in_valid` while `in_ready` is 0 produces no `out_valid`.
- R9: Lane i uses the offset of the sensor numbered by `in_sel[3i+2:3i]`. Lanes that share a code but name different sensors get results that follow their own offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_load | input | 1 | Capture calibration and recompute scale |
| cal_gain_err | input | 10 | Gain error, unsigned |
| cal_vts | input | 45 | Per-sensor offsets, 9 bits each, sensor s at [9s+8:9s] |
| cal_ref | input | 6 | Reference temperature in half-degree steps |
| cal_slope | input | 6 | Slope trim magnitude |
| cal_slope_neg | input | 1 | Slope sign qualifier |
| cal_slope_id | input | 1 | Slope sign second qualifier |
| busy | output | 1 | Scale computation running |
| done | output | 1 | One-cycle pulse when scale is ready |
| in_ready | output | 1 | Scale valid and idle; conversions accepted |
| in_valid | input | 1 | Conversion request |
| in_code | input | 64 | Four raw codes, lane i at [16i+15:16i] |
| in_sel | input | 12 | Sensor index per lane, lane i at [3i+2:3i] |
| in_en | input | 4 | Lanes that are members of the bank |
| out_valid | output | 1 | Results valid this cycle |
| out_temp | output | 128 | Lane results, signed millidegrees, lane i at [32i+31:32i] |
| out_max | output | 32 | Bank maximum, signed millidegrees |

## Verification
The defaults are tried with directed codes at three points. One code gives a zero difference term and must read exactly the reference temperature. Code 0 must be clamped to zero. Code 4095 gives a negative value, and with every lane at 4095 the maximum must stay negative rather than fall back to zero. Random calibration sets are tried with random codes, sensor indices, enable masks and junk upper bits. These separate errors in division order, truncation, the arithmetic shift, offset selection and enable handling. All four slope-qualifier combinations are tried with the largest trim, so that a wrong sign rule changes the scale. Requests made while the scale is being recomputed must stay unanswered.

// File: rtl/thermo_cal_max.sv
module thermo_cal_max #(
  parameter int LANES    = 4,
  parameter int NUM_SENS = 5,
  parameter int RAW_W    = 16,
  parameter int CODE_W   = 12,
  parameter int GE_W     = 10,
  parameter int VTS_W    = 9,
  parameter int REF_W    = 6,
  parameter int SLOPE_W  = 6,
  localparam int IDX_W   = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cal_load,
  input  logic [GE_W-1:0]           cal_gain_err,
  input  logic [NUM_SENS*VTS_W-1:0] cal_vts,
  input  logic [REF_W-1:0]          cal_ref,
  input  logic [SLOPE_W-1:0]        cal_slope,
  input  logic                      cal_slope_neg,
  input  logic                      cal_slope_id,
  output logic                      busy,
  output logic                      done,
  output logic                      in_ready,
  input  logic                      in_valid,
  input  logic [LANES*RAW_W-1:0]    in_code,
  input  logic [LANES*IDX_W-1:0]    in_sel,
  input  logic [LANES-1:0]          in_en,
  output logic                      out_valid,
  output logic [LANES*32-1:0]       out_temp,
  output logic [31:0]               out_max
);

  localparam logic [31:0] NUMER    = 32'd1627604160;
  localparam logic [31:0] CODE_MSK = 32'((64'd1 << CODE_W) - 1);
  localparam logic signed [31:0] HOT_LIM = 32'sd200000;

  logic [GE_W-1:0]  ge_q;
  logic [VTS_W-1:0] vts_q [NUM_SENS];
  logic [REF_W-1:0] ref_q;
  logic [1:0]  phase;
  logic [4:0]  cnt;
  logic [31:0] rem, quo, dvs, scale_q;
  logic        scale_ok;

  logic signed [31:0] slope_eff;
  assign slope_eff = (cal_slope_neg && cal_slope_id) ? -$signed(32'(cal_slope))
                                                     :  $signed(32'(cal_slope));

  logic [32:0] sh;
  logic        take;
  logic [31:0] rem_n;
  assign sh    = {rem, quo[31]};
  assign take  = sh >= {1'b0, dvs};
  assign rem_n = take ? 32'(sh - {1'b0, dvs}) : sh[31:0];

  assign busy     = phase != 2'd0;
  assign in_ready = scale_ok && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ge_q     <= GE_W'(512);
      for (int s = 0; s < NUM_SENS; s++) vts_q[s] <= VTS_W'(260);
      ref_q    <= REF_W'(40);
      phase    <= 2'd1;
      cnt      <= '0;
      rem      <= '0;
      quo      <= NUMER;
      dvs      <= 32'd165;
      scale_q  <= '0;
      scale_ok <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cal_load) begin
        ge_q  <= cal_gain_err;
        for (int s = 0; s < NUM_SENS; s++) vts_q[s] <= cal_vts[s*VTS_W +: VTS_W];
        ref_q    <= cal_ref;
        phase    <= 2'd1;
        cnt      <= '0;
        rem      <= '0;
        quo      <= NUMER;
        dvs      <= 32'(32'sd165 + slope_eff);
        scale_ok <= 1'b0;
      end else if (busy) begin
        rem <= rem_n;
        quo <= {quo[30:0], take};
        cnt <= cnt + 5'd1;
        if (cnt == 5'd31) begin
          rem <= '0;
          if (phase == 2'd1) begin
            phase <= 2'd2;
            dvs   <= 32'd10000 + 32'(ge_q);
          end else begin
            phase    <= 2'd0;
            scale_q  <= {quo[30:0], take};
            scale_ok <= 1'b1;
            done     <= 1'b1;
          end
        end
      end
    end
  end

  logic signed [31:0] conv [LANES];
  logic signed [31:0] base;
  assign base = $signed(32'(ref_q) * 32'd500);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [VTS_W-1:0]   off;
    logic signed [31:0] diff, prod, tmp, t;
    always_comb begin
      off = '0;
      for (int s = 0; s < NUM_SENS; s++)
        if (in_sel[i*IDX_W +: IDX_W] == IDX_W'(s)) off = vts_q[s];
    end
    assign diff = $signed((32'(in_code[i*RAW_W +: RAW_W]) & CODE_MSK) - 32'(off) - 32'd3350);
    assign prod = $signed(scale_q) * diff;
    assign tmp  = prod >>> 3;
    assign t    = base - tmp;
    assign conv[i] = (t > HOT_LIM) ? 32'sd0 : t;
  end

  logic signed [31:0] mx;
  always_comb begin
    mx = 32'sh80000000;
    for (int i = 0; i < LANES; i++)
      if (in_en[i] && conv[i] > mx) mx = conv[i];
  end

  logic [LANES-1:0] en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_temp  <= '0;
      out_max   <= '0;
      en_q      <= '0;
    end else begin
      out_valid <= in_valid && in_ready;
      if (in_valid && in_ready) begin
        for (int i = 0; i < LANES; i++) out_temp[i*32 +: 32] <= conv[i];
        out_max <= mx;
        en_q    <= in_en;
      end
    end
  end

  // R2
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && in_ready));
  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load |=> busy);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R6
    hot_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $signed(out_temp[i*32 +: 32]) <= HOT_LIM);
    // R7
    max_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && en_q[i]) |-> $signed(out_max) >= $signed(out_temp[i*32 +: 32]));
  end

endmodule

// File: tb/thermo_cal_max_bench.sv
`timescale 1ns/1ps
module thermo_cal_max_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cal_load, cal_slope_neg, cal_slope_id, in_valid;
  logic [9:0]  cal_gain_err;
  logic [44:0] cal_vts;
  logic [5:0]  cal_ref, cal_slope;
  logic [63:0] in_code;
  logic [11:0] in_sel;
  logic [3:0]  in_en;
  logic busy, done, in_ready, out_valid;
  logic [127:0] out_temp;
  logic [31:0]  out_max;

  thermo_cal_max u_thermo_cal_max (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_gain_err(cal_gain_err),
    .cal_vts(cal_vts), .cal_ref(cal_ref), .cal_slope(cal_slope),
    .cal_slope_neg(cal_slope_neg), .cal_slope_id(cal_slope_id),
    .busy(busy), .done(done), .in_ready(in_ready), .in_valid(in_valid),
    .in_code(in_code), .in_sel(in_sel), .in_en(in_en),
    .out_valid(out_valid), .out_temp(out_temp), .out_max(out_max));

  int total = 0, bad = 0;
  int m_ge, m_ref, m_scale;
  int m_vts [5];
  int c_code [4];
  int c_sel [4];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_scale(int ge, int sl);
    int q;
    q = 1627604160 / (165 + sl);
    q = q / (10000 + ge);
    return q;
  endfunction

  function automatic int exp_temp(int code, int off, int sc, int rf);
    int d, p, t;
    d = (code & 'hfff) - off - 3350;
    p = sc * d;
    p = p >>> 3;
    t = rf * 500 - p;
    if (t > 200000) t = 0;
    return t;
  endfunction

  task automatic load_cal(int ge, int rf, int mag, bit sg, bit id, bit poke);
    int n, sl;
    @(negedge clk);
    cal_gain_err = 10'(ge); cal_ref = 6'(rf); cal_slope = 6'(mag);
    cal_slope_neg = sg; cal_slope_id = id;
    for (int s = 0; s < 5; s++) cal_vts[s*9 +: 9] = 9'(m_vts[s]);
    cal_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cal_load = 1'b0;
    chk("R2 busy after load", int'(busy), 1);
    if (poke) in_valid = 1'b1;
    n = 0;
    while (!done && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (poke && n < 4) chk("R8 request while busy", int'(out_valid), 0);
      if (n == 4) in_valid = 1'b0;
    end
    chk("R2 cycles to done", n, 64);
    chk("R2 ready at done", int'(in_ready), 1);
    sl = (sg && id) ? -mag : mag;
    m_ge = ge; m_ref = rf; m_scale = exp_scale(ge, sl);
  endtask

  task automatic convert(bit [3:0] en, bit [3:0] junk, string tag);
    int e, mx;
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      in_code[l*16 +: 16] = {junk, 12'(c_code[l])};
      in_sel[l*3 +: 3] = 3'(c_sel[l]);
    end
    in_en = en; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " out_valid"}, int'(out_valid), 1);
    mx = 32'h80000000;
    for (int l = 0; l < 4; l++) begin
      e = exp_temp(c_code[l], m_vts[c_sel[l]], m_scale, m_ref);
      chk(tag, int'(out_temp[l*32 +: 32]), e);
      if (en[l] && e > mx) mx = e;
    end
    chk({tag, " R7 max"}, int'(out_max), mx);
    @(posedge clk);
    @(negedge clk);
    chk("R8 single pulse", int'(out_valid), 0);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cal_load = 1'b0; in_valid = 1'b0; cal_gain_err = '0; cal_vts = '0;
    cal_ref = '0; cal_slope = '0; cal_slope_neg = 1'b0; cal_slope_id = 1'b0;
    in_code = '0; in_sel = '0; in_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 ready in reset", int'(in_ready), 0);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 1);
    chk("R1 ready after reset", int'(in_ready), 0);
    for (int n = 0; n < 200 && !in_ready; n++) @(negedge clk);
    chk("R1 ready on defaults", int'(in_ready), 1);
    m_ge = 512; m_ref = 40; m_scale = exp_scale(512, 0);
    for (int s = 0; s < 5; s++) m_vts[s] = 260;

    // R1 R5: zero difference term reads reference; R6: code 0 clamps
    c_code = '{3610, 0, 4095, 3610}; c_sel = '{0, 1, 2, 4};
    convert(4'b1111, 4'h0, "R1 R5 defaults");
    chk("R5 zero diff", int'(out_temp[31:0]), 20000);
    chk("R6 hot clamp", int'(out_temp[63:32]), 0);
    chk("R5 negative", int'(out_temp[95:64]), -36866);
    // R7: all negative, max stays negative
    c_code = '{4095, 4095, 4095, 4095};
    convert(4'b1111, 4'h0, "R7 negative bank");
    chk("R7 negative max", int'(out_max), -36866);
    // R7: no lanes enabled
    convert(4'b0000, 4'h0, "R7 empty bank");
    // R4: junk upper bits
    c_code = '{3610, 100, 2000, 4000};
    convert(4'b1011, 4'hF, "R4 upper bits ignored");

    // R3: all qualifier combinations with the largest trim
    for (int k = 0; k < 4; k++) begin
      load_cal(300, 25, 63, k[0], k[1], 1'b0);
      c_code = '{3000, 3500, 3900, 2500}; c_sel = '{0, 1, 2, 3};
      convert(4'b1111, 4'h0, "R3 slope sign");
    end

    // R8: requests during recompute are ignored
    load_cal(512, 40, 0, 1'b0, 1'b0, 1'b1);

    // R9 + random sweep
    for (int r = 0; r < 20; r++) begin
      for (int s = 0; s < 5; s++) m_vts[s] = int'($urandom % 512);
      load_cal(int'($urandom % 1024), int'($urandom % 64), int'($urandom % 64),
               1'($urandom), 1'($urandom), 1'b0);
      for (int j = 0; j < 8; j++) begin
        for (int l = 0; l < 4; l++) begin
          c_code[l] = (j == 0) ? 3400 : int'($urandom % 4096);
          c_sel[l]  = (j == 0) ? l + 1 : int'($urandom % 5);
        end
        convert(4'($urandom), 4'($urandom), "R5 R9 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule